// File: doc/BRIEF.md
# Sectored Instruction Decoder

This block accepts one instruction syllable per fetch strobe. A syllable is 14 bits: 13 data bits and one parity bit. The block checks parity, names the instruction, and builds the full operand address. Only 16 opcode values fit in the 4-bit opcode field, yet the instruction set has 18 members. One opcode value is therefore shared by three instructions, and two bits of the address field tell them apart. Data words are two syllables long; this block handles only the single-syllable instruction.

Operand addresses are relative to a 256-word sector. An 8-bit word offset is combined with a sector number. A select bit in the syllable picks that sector number: either the current sector, which software loads through a strobe, or a fixed residual sector given as a parameter. All decode results are registered and appear one clock after the fetch strobe. A parity failure sets a sticky flag.

Top module: `sector_insn_decoder`

## Requirements
- R1: Syllable layout: bits [3:0] hold the opcode, [11:4] the word offset, bit 12 the sector select, and bit 13 the parity bit. Any opcode other than the shared value (15 by default) yields `insn_code` equal to that opcode.
- R2: For the shared opcode, word bits [1:0] (syllable bits [5:4]) pick the instruction: 0 gives code 16, 1 gives 17, 2 gives 18, and 3 gives the illegal code 31.
- R3: For the shared opcode, `eff_addr` is 0 and `opnd_used` is 0.
- R4: For a non-shared opcode with select bit 0, `eff_addr` is {current sector, word offset} and `opnd_used` is 1.
- R5: For a non-shared opcode with select bit 1, `eff_addr` is {residual sector (15 by default), word offset}.
- R6: A pulse on `sect_ld` loads `sect_in` into the current sector. A fetch in the same cycle as a load still uses the previous sector.
- R7: Parity is odd across all 14 syllable bits. A fetched syllable with an even count of ones sets `par_err` on the next clock.
- R8: `par_err` stays set until reset or `err_clr`. If `err_clr` and a bad fetch fall in the same cycle, `par_err` stays set.
- R9: `out_vld` is a one-cycle pulse, one clock after `fetch_vld`. `insn_code`, `eff_addr` and `opnd_used` hold their values between fetches.
- R10: Reset clears `out_vld`, `insn_code`, `eff_addr`, `opnd_used`, `par_err` and the current sector to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_vld | input | 1 | Syllable on `syl` is valid this cycle |
| syl | input | 14 | Instruction syllable including parity |
| sect_ld | input | 1 | Load strobe for the current sector |
| sect_in | input | 4 | New current sector number |
| err_clr | input | 1 | Clears the sticky parity flag |
| out_vld | output | 1 | Decode results updated this cycle |
| insn_code | output | 5 | Resolved instruction number |
| eff_addr | output | 12 | Sector and word operand address |
| opnd_used | output | 1 | The operand address is meaningful |
| par_err | output | 1 | Sticky parity failure flag |

## Verification
Two pairs of events can land in the same cycle. In the first, a sector load coincides with a fetch. The bench loads a new sector together with a current-sector fetch, and checks that this fetch is addressed with the old sector while the next fetch uses the new one. In the second, a parity clear coincides with a bad syllable. The bench drives both together and checks that the flag is still set afterwards, and that a later clear alone removes it.

// File: rtl/sid_pkg.sv
package sid_pkg;
  localparam int OP_W   = 4;
  localparam int CODE_W = 5;
  localparam int EXT_W  = 2;

  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_ILLEGAL = '1;
  localparam code_t CODE_EXT_BASE = code_t'(2 ** OP_W);

  // Resolve a 4-bit opcode plus two extension bits into an instruction number.
  function automatic code_t resolve_code(input logic [OP_W-1:0] op,
                                         input logic [OP_W-1:0] shared_op,
                                         input logic [EXT_W-1:0] ext);
    if (op != shared_op) return code_t'(op);
    if (ext == '1) return CODE_ILLEGAL;
    return CODE_EXT_BASE + code_t'(ext);
  endfunction
endpackage

// File: rtl/sid_parity.sv
module sid_parity #(
  parameter int W = 14
) (
  input  logic [W-1:0] word_in,
  output logic         odd_ok
);
  assign odd_ok = ^word_in;
endmodule

// File: rtl/sid_sector_reg.sv
module sid_sector_reg #(
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [SECT_W-1:0] din,
  output logic [SECT_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= din;
  end
endmodule

// File: rtl/sid_addr_form.sv
module sid_addr_form #(
  parameter int SECT_W     = 4,
  parameter int WORD_W     = 8,
  parameter int RESID_SECT = 15,
  localparam int ADDR_W    = SECT_W + WORD_W
) (
  input  logic [SECT_W-1:0] cur_sect,
  input  logic              resid_sel,
  input  logic [WORD_W-1:0] word,
  input  logic              is_shared,
  output logic [ADDR_W-1:0] addr,
  output logic              used
);
  localparam logic [SECT_W-1:0] RESID = SECT_W'(RESID_SECT);
  logic [SECT_W-1:0] sect_pick;

  assign sect_pick = resid_sel ? RESID : cur_sect;

  always_comb begin
    if (is_shared) begin
      addr = '0;
      used = 1'b0;
    end else begin
      addr = {sect_pick, word};
      used = 1'b1;
    end
  end
endmodule

// File: rtl/sector_insn_decoder.sv
module sector_insn_decoder
  import sid_pkg::*;
#(
  parameter int SECT_W     = 4,
  parameter int WORD_W     = 8,
  parameter int RESID_SECT = 15,
  parameter int SHARED_OP  = 15,
  localparam int SYL_W     = OP_W + WORD_W + 2,
  localparam int ADDR_W    = SECT_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_vld,
  input  logic [SYL_W-1:0]  syl,
  input  logic              sect_ld,
  input  logic [SECT_W-1:0] sect_in,
  input  logic              err_clr,
  output logic              out_vld,
  output logic [CODE_W-1:0] insn_code,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              opnd_used,
  output logic              par_err
);
  localparam int SEL_BIT = OP_W + WORD_W;
  localparam logic [OP_W-1:0] SHARED = OP_W'(SHARED_OP);

  logic [OP_W-1:0]   op_f;
  logic [WORD_W-1:0] word_f;
  logic              resid_sel;
  logic              is_shared;
  logic              par_ok;
  logic              fetch_bad;
  logic [SECT_W-1:0] cur_sect;
  logic [ADDR_W-1:0] nxt_addr;
  logic              nxt_used;
  code_t             nxt_code;

  assign op_f      = syl[OP_W-1:0];
  assign word_f    = syl[SEL_BIT-1:OP_W];
  assign resid_sel = syl[SEL_BIT];
  assign is_shared = (op_f == SHARED);
  assign nxt_code  = resolve_code(op_f, SHARED, word_f[EXT_W-1:0]);
  assign fetch_bad = fetch_vld && !par_ok;

  sid_parity #(.W(SYL_W)) u_par (
    .word_in (syl),
    .odd_ok  (par_ok)
  );

  sid_sector_reg #(.SECT_W(SECT_W)) u_sect (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (sect_ld),
    .din   (sect_in),
    .q     (cur_sect)
  );

  sid_addr_form #(.SECT_W(SECT_W), .WORD_W(WORD_W), .RESID_SECT(RESID_SECT)) u_addr (
    .cur_sect  (cur_sect),
    .resid_sel (resid_sel),
    .word      (word_f),
    .is_shared (is_shared),
    .addr      (nxt_addr),
    .used      (nxt_used)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld   <= 1'b0;
      insn_code <= '0;
      eff_addr  <= '0;
      opnd_used <= 1'b0;
      par_err   <= 1'b0;
    end else begin
      out_vld <= fetch_vld;
      if (fetch_vld) begin
        insn_code <= nxt_code;
        eff_addr  <= nxt_addr;
        opnd_used <= nxt_used;
      end
      if (fetch_bad)    par_err <= 1'b1;
      else if (err_clr) par_err <= 1'b0;
    end
  end
endmodule

// File: rtl/sector_insn_decoder_chk.sv
module sector_insn_decoder_chk
  import sid_pkg::*;
#(
  parameter int SECT_W     = 4,
  parameter int WORD_W     = 8,
  parameter int RESID_SECT = 15,
  parameter int SHARED_OP  = 15,
  localparam int SYL_W     = OP_W + WORD_W + 2,
  localparam int ADDR_W    = SECT_W + WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_vld,
  input logic [SYL_W-1:0]  syl,
  input logic              sect_ld,
  input logic [SECT_W-1:0] sect_in,
  input logic              err_clr,
  input logic              out_vld,
  input logic [CODE_W-1:0] insn_code,
  input logic [ADDR_W-1:0] eff_addr,
  input logic              opnd_used,
  input logic              par_err,
  input logic [SECT_W-1:0] cur_sect
);
  localparam int SEL_BIT = OP_W + WORD_W;
  logic bad_cnt;
  logic shared_now;
  assign bad_cnt    = ($countones(syl) % 2) == 0;
  assign shared_now = (int'(syl[OP_W-1:0]) == SHARED_OP);

  assert_vld_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld |=> out_vld);
  assert_vld_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld |=> !out_vld && $stable(insn_code) && $stable(eff_addr) && $stable(opnd_used));
  assert_shared_noaddr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld && shared_now |=> eff_addr == '0 && !opnd_used);
  assert_resid_sector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld && !shared_now && syl[SEL_BIT] |=>
      int'(eff_addr[ADDR_W-1:WORD_W]) == RESID_SECT && opnd_used);
  assert_sect_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sect_ld |=> cur_sect == $past(sect_in));
  assert_bad_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld && bad_cnt |=> par_err);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    par_err && !err_clr |=> par_err);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !(fetch_vld && bad_cnt) |=> !par_err);
endmodule

bind sector_insn_decoder sector_insn_decoder_chk #(
  .SECT_W(SECT_W), .WORD_W(WORD_W), .RESID_SECT(RESID_SECT), .SHARED_OP(SHARED_OP)
) u_chk (.*);

// File: tb/sector_insn_decoder_tb.sv
`timescale 1ns/1ps
module sector_insn_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_vld = 1'b0;
  logic [13:0] syl = '0;
  logic        sect_ld = 1'b0;
  logic [3:0]  sect_in = '0;
  logic        err_clr = 1'b0;
  logic        out_vld;
  logic [4:0]  insn_code;
  logic [11:0] eff_addr;
  logic        opnd_used;
  logic        par_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sector_insn_decoder u_dut (.*);

  // fields: op(4) sel(1) word(8) | code(5) addr(12) used(1); current sector is 3
  localparam int NV = 8;
  localparam logic [30:0] VEC [NV] = '{
    {4'd0,  1'b0, 8'h12, 5'd0,  12'h312, 1'b1},
    {4'd5,  1'b1, 8'hA7, 5'd5,  12'hFA7, 1'b1},
    {4'd14, 1'b0, 8'hFF, 5'd14, 12'h3FF, 1'b1},
    {4'd15, 1'b0, 8'h00, 5'd16, 12'h000, 1'b0},
    {4'd15, 1'b1, 8'h01, 5'd17, 12'h000, 1'b0},
    {4'd15, 1'b0, 8'hFE, 5'd18, 12'h000, 1'b0},
    {4'd15, 1'b1, 8'h03, 5'd31, 12'h000, 1'b0},
    {4'd9,  1'b1, 8'h00, 5'd9,  12'hF00, 1'b1}
  };

  function automatic logic [13:0] mk(input logic [3:0] op, input logic sel,
                                     input logic [7:0] word, input logic corrupt);
    logic [12:0] body;
    logic p;
    body = {sel, word, op};
    p = 1'b1;
    for (int i = 0; i < 13; i++) if (body[i]) p = ~p;
    return {p ^ corrupt, body};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [13:0] s);
    @(negedge clk);
    syl = s;
    fetch_vld = 1'b1;
    @(negedge clk);
    fetch_vld = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 out_vld", out_vld, 0);
    chk("R10 code", insn_code, 0);
    chk("R10 addr", eff_addr, 0);
    chk("R10 used", opnd_used, 0);
    chk("R10 par_err", par_err, 0);
    rst_n = 1'b1;

    @(negedge clk);
    sect_in = 4'd3;
    sect_ld = 1'b1;
    @(negedge clk);
    sect_ld = 1'b0;

    for (int k = 0; k < NV; k++) begin
      fetch(mk(VEC[k][30:27], VEC[k][26], VEC[k][25:18], 1'b0));
      chk("R9 out_vld", out_vld, 1);
      chk("R1 R2 code", insn_code, VEC[k][17:13]);
      chk("R3 R4 R5 addr", eff_addr, VEC[k][12:1]);
      chk("R3 R4 used", opnd_used, VEC[k][0]);
    end
    chk("R7 no error on good parity", par_err, 0);

    // hold between fetches
    @(negedge clk);
    chk("R9 pulse ends", out_vld, 0);
    chk("R9 code held", insn_code, 9);
    chk("R9 addr held", eff_addr, 12'hF00);

    // sector load coincident with fetch
    @(negedge clk);
    sect_in = 4'd7;
    sect_ld = 1'b1;
    syl = mk(4'd2, 1'b0, 8'h44, 1'b0);
    fetch_vld = 1'b1;
    @(negedge clk);
    sect_ld = 1'b0;
    fetch_vld = 1'b0;
    chk("R6 old sector on same-cycle fetch", eff_addr, 12'h344);
    fetch(mk(4'd2, 1'b0, 8'h44, 1'b0));
    chk("R6 new sector next fetch", eff_addr, 12'h744);

    // parity failure and stickiness
    fetch(mk(4'd1, 1'b0, 8'h10, 1'b1));
    chk("R7 bad parity sets flag", par_err, 1);
    chk("R1 decode still updates", insn_code, 1);
    fetch(mk(4'd1, 1'b0, 8'h10, 1'b0));
    chk("R8 flag sticky over good fetch", par_err, 1);
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R8 clear removes flag", par_err, 0);

    // clear and bad fetch in the same cycle
    @(negedge clk);
    err_clr = 1'b1;
    syl = mk(4'd6, 1'b1, 8'h55, 1'b1);
    fetch_vld = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    fetch_vld = 1'b0;
    chk("R8 set wins over clear", par_err, 1);

    // reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 par_err after reset", par_err, 0);
    chk("R10 addr after reset", eff_addr, 0);
    rst_n = 1'b1;
    fetch(mk(4'd3, 1'b0, 8'h20, 1'b0));
    chk("R10 sector cleared by reset", eff_addr, 12'h020);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule